// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps one reservation per hardware thread context for a memory that several contexts share. A locked load records a reservation for its context. A later store-conditional from that context is checked against that reservation. The block then decides whether the store goes to memory and which result code goes back to the core.

Reservations compare at 16-byte granule resolution, which means address bits [3:0] are ignored. Any store that reaches memory removes every reservation on its granule, in every context. A failed conditional never reaches memory and removes nothing except its own context's reservation.

Each context counts its consecutive conditional failures in a saturating counter. A one-cycle warning, tagged with the context number, fires each time the count reaches a multiple of `WARN_PERIOD`.

Requests arrive through a valid/ready handshake, one per cycle. Every response is registered and appears in the cycle after the request is accepted.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset, `rsp_valid`, `mem_commit` and `warn_valid` are low and no context holds a reservation, so a cacheable store-conditional returns code 0 and does not commit.
- R2: A locked load (`req_write`=0, `req_locked`=1) reserves the granule `req_addr[AW-1:4]` for `req_ctx`. A cacheable store-conditional from that context to any byte of the same granule returns code 1 and raises `mem_commit`.
- R3: A cacheable store-conditional whose granule differs from a valid reservation returns code 1 but does not commit, and it drops that reservation. A later conditional from the same context returns 0.
- R4: A cacheable store-conditional returns as its code the reservation flag held before the request (0 or 1). With the flag clear it returns 0 and does not commit.
- R5: A store-conditional with `req_uncache`=1 always returns code 2, always commits, and resets its context's failure count to zero.
- R6: A plain store (`req_write`=1, `req_locked`=0) commits. It clears the reservation of every context whose granule matches its own and leaves reservations on other granules intact.
- R7: A committed store-conditional also clears every matching reservation, including the issuer's own. A failed conditional clears no other context's reservation.
- R8: A failed cacheable conditional increments its context's failure count. A successful or uncacheable conditional resets it. `warn_valid` pulses with `warn_ctx`=context when the count becomes a nonzero multiple of `WARN_PERIOD`.
- R9: The failure count saturates at 2^CNT_W-1. Failures beyond that point raise no further warning.
- R10: Plain loads neither reserve nor clear anything and produce no response. `req_ready` is high out of reset.
- R11: `rsp_valid` pulses only for store-conditionals, and `mem_commit` only for stores, in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request accepted |
| req_ctx | input | $clog2(NCTX) | Issuing context |
| req_addr | input | AW | Physical address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_locked | input | 1 | Locked load or store-conditional |
| req_uncache | input | 1 | Uncacheable attribute |
| rsp_valid | output | 1 | Store-conditional result valid |
| rsp_code | output | 2 | 0 fail, 1 flag set, 2 uncacheable |
| mem_commit | output | 1 | Store is forwarded to memory |
| warn_valid | output | 1 | Repeated-failure warning pulse |
| warn_ctx | output | $clog2(NCTX) | Context of the warning |

## Verification
The hardest states to reach from the ports are the failure-count boundaries: a warning at each period multiple and silence once the count saturates. With the default parameters, reaching them would take hundreds of thousands of failures. The bench therefore shrinks `CNT_W` and `WARN_PERIOD`. It then drives long runs of failing conditionals from a single context until the count wraps past several periods into saturation. Cross-context clearing is exercised by reservations placed in different low-order bytes of one granule, followed by stores from other contexts.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int NCTX        = 4,
  parameter int AW          = 32,
  parameter int CNT_W       = 20,
  parameter int WARN_PERIOD = 100000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [$clog2(NCTX)-1:0] req_ctx,
  input  logic [AW-1:0]           req_addr,
  input  logic                    req_write,
  input  logic                    req_locked,
  input  logic                    req_uncache,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_code,
  output logic                    mem_commit,
  output logic                    warn_valid,
  output logic [$clog2(NCTX)-1:0] warn_ctx
);
  localparam int CW = $clog2(NCTX);
  localparam int GW = AW - 4;
  localparam int PW = $clog2(WARN_PERIOD);

  logic [NCTX-1:0]  rsv_vld;
  logic [GW-1:0]    rsv_gran [NCTX];
  logic [CNT_W-1:0] fail_cnt [NCTX];
  logic [PW-1:0]    phase    [NCTX];

  logic unused_low;
  assign unused_low = ^req_addr[3:0];

  assign req_ready = ~rst;

  wire          fire     = req_valid & req_ready;
  wire [GW-1:0] gran     = req_addr[AW-1:4];
  wire          is_ll    = fire & ~req_write & req_locked;
  wire          is_sc    = fire & req_write & req_locked;
  wire          own_flag = rsv_vld[req_ctx];
  wire          own_hit  = own_flag && (rsv_gran[req_ctx] == gran);
  wire          sc_ok    = is_sc & (req_uncache | own_hit);
  wire          sc_fail  = is_sc & ~sc_ok;
  wire          commit   = fire & req_write & (~req_locked | sc_ok);
  wire          cnt_sat  = &fail_cnt[req_ctx];
  wire          warn_now = sc_fail & ~cnt_sat &
                           (phase[req_ctx] == PW'(WARN_PERIOD - 1));

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    wire mine = (req_ctx == CW'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        rsv_vld[i]  <= 1'b0;
        rsv_gran[i] <= '0;
        fail_cnt[i] <= '0;
        phase[i]    <= '0;
      end else begin
        if (is_ll && mine) begin
          rsv_vld[i]  <= 1'b1;
          rsv_gran[i] <= gran;
        end else if (commit && rsv_vld[i] && rsv_gran[i] == gran) begin
          rsv_vld[i] <= 1'b0;
        end else if (sc_fail && mine) begin
          rsv_vld[i] <= 1'b0;
        end
        if (is_sc && mine) begin
          if (sc_ok) begin
            fail_cnt[i] <= '0;
            phase[i]    <= '0;
          end else if (!cnt_sat) begin
            fail_cnt[i] <= fail_cnt[i] + 1'b1;
            phase[i]    <= warn_now ? '0 : phase[i] + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_code   <= 2'd0;
      mem_commit <= 1'b0;
      warn_valid <= 1'b0;
      warn_ctx   <= '0;
    end else begin
      rsp_valid  <= is_sc;
      rsp_code   <= req_uncache ? 2'd2 : {1'b0, own_flag};
      mem_commit <= commit;
      warn_valid <= warn_now;
      warn_ctx   <= req_ctx;
    end
  end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic       req_locked,
  input logic       req_uncache,
  input logic       rsp_valid,
  input logic [1:0] rsp_code,
  input logic       mem_commit,
  input logic       warn_valid
);
  // R11
  rsp_only_sc_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready && req_write && req_locked));
  // R11
  commit_only_store_chk: assert property (@(posedge clk) disable iff (rst)
    mem_commit |-> $past(req_valid && req_ready && req_write));
  // R5
  uncache_code_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write && req_locked && req_uncache) |=> (rsp_code == 2'd2 && mem_commit));
  // R4
  clear_flag_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 2'd0) |-> !mem_commit);
  // R8
  warn_on_fail_chk: assert property (@(posedge clk) disable iff (rst)
    warn_valid |-> (rsp_valid && !mem_commit && rsp_code != 2'd2));
  // R10
  plain_load_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> (!rsp_valid && !mem_commit));
endmodule

bind lrsc_monitor lrsc_monitor_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_locked(req_locked), .req_uncache(req_uncache),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .mem_commit(mem_commit),
  .warn_valid(warn_valid)
);

// File: tb/sim_lrsc_monitor.sv
module sim_lrsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NCTX = 4;
  localparam int AW = 16;
  localparam int CNT_W = 4;
  localparam int PER = 5;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready, req_write = 0, req_locked = 0, req_uncache = 0;
  logic [1:0] req_ctx = 0;
  logic [AW-1:0] req_addr = 0;
  logic rsp_valid, mem_commit, warn_valid;
  logic [1:0] rsp_code, warn_ctx;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_flag [NCTX];
  int m_gran [NCTX];
  int m_cnt  [NCTX];

  always #(CLK_PERIOD/2) clk = ~clk;

  lrsc_monitor #(.NCTX(NCTX), .AW(AW), .CNT_W(CNT_W), .WARN_PERIOD(PER)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctx(req_ctx), .req_addr(req_addr), .req_write(req_write),
    .req_locked(req_locked), .req_uncache(req_uncache), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .mem_commit(mem_commit), .warn_valid(warn_valid),
    .warn_ctx(warn_ctx));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, bit w, bit l, bit u, int c, int a);
    int e_rv = 0, e_code = 0, e_com = 0, e_w = 0;
    bit ok = 0;
    int g = a >> 4;
    @(negedge clk);
    req_valid = v; req_write = w; req_locked = l; req_uncache = u;
    req_ctx = 2'(c); req_addr = AW'(a);
    if (v) begin
      if (!w && l) begin
        m_flag[c] = 1; m_gran[c] = g;
      end else if (w) begin
        if (l) begin
          e_rv = 1;
          if (u) begin
            e_code = 2; ok = 1; m_cnt[c] = 0;
          end else begin
            e_code = m_flag[c] ? 1 : 0;
            ok = m_flag[c] && m_gran[c] == g;
            if (ok) m_cnt[c] = 0;
            else begin
              m_flag[c] = 0;
              if (m_cnt[c] < CMAX) begin
                m_cnt[c]++;
                if (m_cnt[c] % PER == 0) e_w = 1;
              end
            end
          end
        end
        if (!l || ok) begin
          e_com = 1;
          for (int j = 0; j < NCTX; j++)
            if (m_flag[j] && m_gran[j] == g) m_flag[j] = 0;
        end
      end
    end
    @(posedge clk); #1;
    chk({tag, " rsp_valid"}, int'(rsp_valid), e_rv);
    if (e_rv) chk({tag, " rsp_code"}, int'(rsp_code), e_code);
    chk({tag, " mem_commit"}, int'(mem_commit), e_com);
    chk({tag, " warn_valid"}, int'(warn_valid), e_w);
    if (e_w) chk({tag, " warn_ctx"}, int'(warn_ctx), c);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCTX; i++) begin m_flag[i] = 0; m_gran[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 mem_commit", int'(mem_commit), 0);
    chk("R1 warn_valid", int'(warn_valid), 0);
    // R10 ready
    chk("R10 req_ready", int'(req_ready), 1);
    step("R1 sc after reset", 1, 1, 1, 0, 0, 'h100);
    // R2 reserve and succeed on another byte of granule
    step("R2 ll", 1, 0, 1, 0, 1, 'h204);
    step("R2 sc", 1, 1, 1, 0, 1, 'h20c);
    // R3 mismatch granule
    step("R3 ll", 1, 0, 1, 0, 2, 'h300);
    step("R3 sc other", 1, 1, 1, 0, 2, 'h310);
    step("R3 sc again", 1, 1, 1, 0, 2, 'h300);
    // R4 flag clear
    step("R4 sc noflag", 1, 1, 1, 0, 3, 'h400);
    // R5 uncacheable
    step("R5 sc unc", 1, 1, 1, 1, 3, 'h400);
    // R6 plain store clears matching only
    step("R6 ll0", 1, 0, 1, 0, 0, 'h500);
    step("R6 ll1", 1, 0, 1, 0, 1, 'h50f);
    step("R6 ll2", 1, 0, 1, 0, 2, 'h600);
    step("R6 st", 1, 1, 0, 0, 3, 'h508);
    step("R6 sc0", 1, 1, 1, 0, 0, 'h500);
    step("R6 sc1", 1, 1, 1, 0, 1, 'h500);
    step("R6 sc2 kept", 1, 1, 1, 0, 2, 'h604);
    // R7 successful sc clears others; failed one clears nothing
    step("R7 ll0", 1, 0, 1, 0, 0, 'h700);
    step("R7 ll1", 1, 0, 1, 0, 1, 'h704);
    step("R7 sc3 fail", 1, 1, 1, 0, 3, 'h700);
    step("R7 sc0 ok", 1, 1, 1, 0, 0, 'h708);
    step("R7 sc1 cleared", 1, 1, 1, 0, 1, 'h700);
    // R10 plain load and idle
    step("R10 ll2", 1, 0, 1, 0, 2, 'h800);
    step("R10 plain ld", 1, 0, 0, 0, 2, 'h900);
    step("R10 idle", 0, 1, 1, 0, 2, 'h800);
    step("R10 sc2", 1, 1, 1, 0, 2, 'h800);
    // R8 warnings, R9 saturation
    for (int k = 0; k < 22; k++) step("R8 R9 fail run", 1, 1, 1, 0, 1, 'ha00);
    step("R8 reset by unc", 1, 1, 1, 1, 1, 'ha00);
    for (int k = 0; k < 6; k++) step("R8 after reset", 1, 1, 1, 0, 1, 'ha00);
    // R11 random mix
    for (int k = 0; k < 3000; k++) begin
      int a = int'($urandom_range(0, 63));
      step("R11 random", 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 9) == 0),
           int'($urandom_range(0, NCTX - 1)), a);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule